// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block serialises words onto a single data line, one bit per clock, most significant bit first. Software or a DMA engine places a word into a two-half holding register. The low half is the commit point: writing it marks the word as pending. At the next free moment the block moves the whole holding register into a shift register, and from there the bits go out in a frame whose length is chosen by `word_len`. Each frame begins on a frame-sync pulse. That pulse is either taken from `sync_in`, or generated inside the block once for every copy into the shift register.

The holding register is kept after a frame has been sent. If a frame sync arrives and no new word has been committed since the last copy, the block is in underflow and sends the held word again. It goes on doing so on every sync until the low half is written. Two status flags follow the buffer: `tx_ready` shows that the holding register may take a new word, and `tx_filled` drops to zero when the buffer is empty or in underflow. Each time `tx_ready` rises, the block emits a one-cycle interrupt and a one-cycle DMA request.

The control state machine has three states. `ST_OFF` is held while `tx_enable` is low. `ST_WAIT` means the line is idle. `ST_SHIFT` means a frame is going out. Its transitions are:
- OFF to WAIT: on the first enabled cycle.
- WAIT to SHIFT: on a copy in per-copy sync mode, or on a sampled `sync_in` in external mode.
- SHIFT to WAIT: after the last bit.
- Any state to OFF: whenever `tx_enable` is low.

Top module: `serial_frame_tx`

## Requirements
- R1: After device reset, and in every cycle while `tx_enable` is low, `tx_ready`=1, `tx_filled`=0, `tx_dout`=0 and `tx_sync_out`=0. Disabling clears both holding halves, so a frame sync that arrives after a restart and before any write sends all zeros.
- R2: A low-half write (`wr_lo`=1 at an enabled clock edge) makes `tx_ready` 0 after that edge. `tx_ready` returns to 1 after the edge that copies the word into the shift register.
- R3: `tx_irq` and `tx_dma_evt` are each high for exactly one cycle, in the cycle in which `tx_ready` has just risen while the block is enabled.
- R4: Frames go out MSB-first, one bit per clock, starting in the cycle after the frame-start edge. `word_len` selects the frame as follows: 0 sends 8 bits (`lo[7:0]`), 1 sends 16 bits (`lo`), and 2 or 3 sends 32 bits (`{hi, lo}`, with `hi` first).
- R5: A high-half write (`wr_hi`) never commits a word. A low-half write copies both halves together, so a high half that was not rewritten is sent with its old contents.
- R6: In per-copy sync mode (`sync_sel_int`=1, `sync_gen_free`=0), every copy starts a frame at once. `tx_sync_out` is high for exactly that frame's first bit cycle, and `sync_in` has no effect.
- R7: In every other mode, a copied word waits in the shift register with the line held low. The frame starts only in the cycle after a `sync_in` pulse has been sampled.
- R8: `tx_filled` rises on a copy. It falls after a frame's last bit only if no low-half write has happened since that copy.
- R9: In external sync mode, a `sync_in` pulse with no new word re-sends the held word, and `tx_filled` stays 0.
- R10: A `sync_in` pulse that arrives while a frame is shifting is ignored, both during that frame and after it.
- R11: `tx_dout` is 0 whenever no frame is in progress.
- R12: A word written after a restart and before the first frame sync is the content of the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit is sent per cycle |
| rst_n | input | 1 | Asynchronous active-low device reset |
| tx_enable | input | 1 | Transmitter enable; low holds the transmitter in reset |
| word_len | input | 2 | Frame length: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| sync_sel_int | input | 1 | Selects internal frame sync |
| sync_gen_free | input | 1 | Frame-sync generator runs freely; when high, frames wait for `sync_in` |
| sync_in | input | 1 | Frame-sync pulse input |
| wr_lo | input | 1 | Write strobe for the low holding half; commits the word |
| wr_hi | input | 1 | Write strobe for the high holding half |
| wr_data | input | 16 | Write data for either half |
| tx_dout | output | 1 | Serial data line |
| tx_sync_out | output | 1 | Internally generated frame-sync pulse |
| tx_ready | output | 1 | Holding register can accept a word |
| tx_filled | output | 1 | 0 = transmitter empty or in underflow |
| tx_irq | output | 1 | Transmit interrupt pulse |
| tx_dma_evt | output | 1 | Transmit DMA request pulse |

## Verification
The hardest case to reach from the ports is the boundary between frames. That covers a new word committed during a frame, a held word waiting for a sync that has not yet come, and a sync that arrives in the middle of a frame. The stimulus places low-half writes and `sync_in` pulses at chosen bit positions inside a frame, counting cycles from the sync edge. It then watches the line for several cycles after the last bit, so that a latched sync or a false underflow would show up as a stray high bit or a wrong `tx_filled`. Restarts through `tx_enable` are placed between these sequences to reach the zero-word case and the write-before-first-sync case.

// File: rtl/sftx_pkg.sv
`timescale 1ns/1ps
package sftx_pkg;
    // Control states of the transmitter.
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } sftx_state_e;

    // Frame length codes on word_len.
    localparam logic [1:0] LEN_BYTE = 2'd0;
    localparam logic [1:0] LEN_HALF = 2'd1;
endpackage

// File: rtl/sftx_hold.sv
`timescale 1ns/1ps
// Holding register: two halves, the pending flag and the ready pulse.
module sftx_hold #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                copy,
    output logic [2*HALF_W-1:0] hold_word,
    output logic                pending,
    output logic                ready,
    output logic                rdy_pulse
);
    logic [HALF_W-1:0] lo_q, hi_q;
    logic              pend_q, pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else if (!en) begin
            lo_q    <= '0;
            hi_q    <= '0;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
            // A fresh low write keeps the buffer busy even on a copy edge (R2).
            pend_q  <= wr_lo | (pend_q & ~copy);
            // Ready rises exactly when a pending word leaves with no new write (R3).
            pulse_q <= pend_q & copy & ~wr_lo;
        end
    end

    assign hold_word = {hi_q, lo_q};
    assign pending   = pend_q;
    assign ready     = ~pend_q;
    assign rdy_pulse = pulse_q;
endmodule

// File: rtl/sftx_shift.sv
`timescale 1ns/1ps
// Shift register with bit counter; word aligned to the MSB on load.
module sftx_shift #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift_en,
    input  logic [1:0]          len_sel,
    input  logic [2*HALF_W-1:0] hold_word,
    output logic                msb,
    output logic                last
);
    import sftx_pkg::*;

    localparam int WORD_W = 2 * HALF_W;
    localparam int BYTE_W = HALF_W / 2;
    localparam int CNT_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] sreg_q, aligned;
    logic [CNT_W-1:0]  cnt_q, top_cnt;

    always_comb begin
        unique case (len_sel)
            LEN_BYTE: begin
                aligned = {hold_word[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
                top_cnt = CNT_W'(BYTE_W - 1);
            end
            LEN_HALF: begin
                aligned = {hold_word[HALF_W-1:0], {(WORD_W-HALF_W){1'b0}}};
                top_cnt = CNT_W'(HALF_W - 1);
            end
            default: begin
                aligned = hold_word;
                top_cnt = CNT_W'(WORD_W - 1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            sreg_q <= aligned;
            cnt_q  <= top_cnt;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign msb  = sreg_q[WORD_W-1];
    assign last = (cnt_q == '0);
endmodule

// File: rtl/sftx_ctrl.sv
`timescale 1ns/1ps
// Frame control state machine.
module sftx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic per_copy,
    input  logic sync_in,
    input  logic pending,
    input  logic wr_lo,
    input  logic last,
    output logic copy,
    output logic load,
    output logic shift_en,
    output logic active,
    output logic sync_pulse,
    output logic filled
);
    import sftx_pkg::*;

    sftx_state_e state_q, state_d;
    logic staged_q, staged_d;
    logic filled_q, filled_d;
    logic sync_q, sync_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_WAIT;
                ST_WAIT:  if (per_copy ? pending : sync_in) state_d = ST_SHIFT;
                ST_SHIFT: if (last) state_d = ST_WAIT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // Outputs and flag updates.
    always_comb begin
        copy     = 1'b0;
        load     = 1'b0;
        shift_en = 1'b0;
        sync_d   = 1'b0;
        staged_d = staged_q;
        filled_d = filled_q;
        if (!en) begin
            staged_d = 1'b0;
            filled_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    staged_d = 1'b0;
                    filled_d = 1'b0;
                end
                ST_WAIT: begin
                    if (per_copy) begin
                        staged_d = 1'b0;
                        if (pending) begin
                            copy     = 1'b1;
                            load     = 1'b1;
                            sync_d   = 1'b1;
                            filled_d = 1'b1;
                        end
                    end else if (sync_in) begin
                        // Staged word goes out as is; otherwise reload (new or resent).
                        load     = ~staged_q;
                        copy     = pending & ~staged_q;
                        staged_d = 1'b0;
                        if (pending && !staged_q) filled_d = 1'b1;
                    end else if (pending && !staged_q) begin
                        copy     = 1'b1;
                        load     = 1'b1;
                        staged_d = 1'b1;
                        filled_d = 1'b1;
                    end
                end
                ST_SHIFT: begin
                    shift_en = 1'b1;
                    if (last && !pending && !wr_lo) filled_d = 1'b0;
                end
                default: begin
                    staged_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= 1'b0;
            filled_q <= 1'b0;
            sync_q   <= 1'b0;
        end else begin
            staged_q <= staged_d;
            filled_q <= filled_d;
            sync_q   <= sync_d;
        end
    end

    assign active     = (state_q == ST_SHIFT);
    assign sync_pulse = sync_q;
    assign filled     = filled_q;
endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic [1:0]        word_len,
    input  logic              sync_sel_int,
    input  logic              sync_gen_free,
    input  logic              sync_in,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    output logic              tx_dout,
    output logic              tx_sync_out,
    output logic              tx_ready,
    output logic              tx_filled,
    output logic              tx_irq,
    output logic              tx_dma_evt
);
    localparam int WORD_W = 2 * HALF_W;

    logic [WORD_W-1:0] hold_word;
    logic pending, rdy_pulse, copy, load, shift_en, active, msb, last;
    logic per_copy;

    assign per_copy = sync_sel_int & ~sync_gen_free;

    sftx_hold #(.HALF_W(HALF_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(tx_enable),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .copy(copy),
        .hold_word(hold_word), .pending(pending), .ready(tx_ready),
        .rdy_pulse(rdy_pulse)
    );

    sftx_shift #(.HALF_W(HALF_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
        .len_sel(word_len), .hold_word(hold_word), .msb(msb), .last(last)
    );

    sftx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(tx_enable), .per_copy(per_copy),
        .sync_in(sync_in), .pending(pending), .wr_lo(wr_lo), .last(last),
        .copy(copy), .load(load), .shift_en(shift_en), .active(active),
        .sync_pulse(tx_sync_out), .filled(tx_filled)
    );

    assign tx_dout    = active & msb;
    assign tx_irq     = rdy_pulse;
    assign tx_dma_evt = rdy_pulse;
endmodule

// File: rtl/serial_frame_tx_checker.sv
`timescale 1ns/1ps
module serial_frame_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_enable,
    input logic wr_lo,
    input logic tx_dout,
    input logic tx_sync_out,
    input logic tx_ready,
    input logic tx_filled,
    input logic tx_irq
);
    assert_irq_on_ready_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_ready && !$past(tx_ready)));

    assert_ready_rise_gives_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_ready) && $past(tx_enable)) |-> tx_irq);

    assert_write_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && wr_lo) |=> !tx_ready);

    assert_restart_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> (tx_ready && !tx_filled && !tx_dout && !tx_sync_out));

    assert_single_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sync_out |=> !tx_sync_out);

    assert_sync_marks_filled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sync_out |-> tx_filled);
endmodule

bind serial_frame_tx serial_frame_tx_checker i_chk (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .wr_lo(wr_lo),
    .tx_dout(tx_dout), .tx_sync_out(tx_sync_out), .tx_ready(tx_ready),
    .tx_filled(tx_filled), .tx_irq(tx_irq)
);

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_enable = 1'b0;
    logic [1:0] word_len = 2'd0;
    logic sync_sel_int = 1'b0;
    logic sync_gen_free = 1'b0;
    logic sync_in = 1'b0;
    logic wr_lo = 1'b0;
    logic wr_hi = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic tx_dout, tx_sync_out, tx_ready, tx_filled, tx_irq, tx_dma_evt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .word_len(word_len),
        .sync_sel_int(sync_sel_int), .sync_gen_free(sync_gen_free),
        .sync_in(sync_in), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .tx_dout(tx_dout), .tx_sync_out(tx_sync_out), .tx_ready(tx_ready),
        .tx_filled(tx_filled), .tx_irq(tx_irq), .tx_dma_evt(tx_dma_evt)
    );

    // {word_len, high half, low half}
    localparam logic [33:0] VECS [0:5] = '{
        {2'd0, 16'h0000, 16'h00A5},
        {2'd1, 16'h0000, 16'h1234},
        {2'd2, 16'hDEAD, 16'hBEEF},
        {2'd0, 16'hFFFF, 16'h013C},
        {2'd1, 16'h7777, 16'h8001},
        {2'd3, 16'h0001, 16'h8000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] l);
        return (l == 2'd0) ? 8 : ((l == 2'd1) ? 16 : 32);
    endfunction

    function automatic logic [31:0] frame_exp(input logic [1:0] l, input logic [15:0] hi,
                                              input logic [15:0] lo);
        if (l == 2'd0)      return {24'h0, lo[7:0]};
        else if (l == 2'd1) return {16'h0, lo};
        else                return {hi, lo};
    endfunction

    // Samples the current cycle, then n-1 more cycles.
    task automatic collect(input int n, output logic [31:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            w = {w[30:0], tx_dout};
        end
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic write_word(input logic [1:0] l, input bit do_hi, input logic [15:0] hi,
                              input logic [15:0] lo);
        word_len = l;
        if (do_hi) begin
            wr_hi = 1'b1; wr_data = hi;
            @(negedge clk);
            wr_hi = 1'b0;
        end
        wr_lo = 1'b1; wr_data = lo;
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] l;
        logic [15:0] hi, lo;
        logic [31:0] w;

        repeat (3) @(negedge clk);
        check(tx_ready && !tx_filled && !tx_dout && !tx_sync_out && !tx_irq,
              "R1 reset state", {27'd0, tx_ready, tx_filled, tx_dout, tx_sync_out, tx_irq},
              32'h10);
        rst_n = 1'b1;
        tx_enable = 1'b1;
        sync_sel_int = 1'b1;
        repeat (2) @(negedge clk);

        // Per-copy internal sync: vector table.
        for (int v = 0; v < 6; v++) begin
            {l, hi, lo} = VECS[v];
            write_word(l, 1'b1, hi, lo);
            check(!tx_ready, "R2 ready after write", 32'(tx_ready), 32'd0);
            @(negedge clk);
            check(tx_sync_out && tx_irq && tx_dma_evt && tx_ready && tx_filled,
                  "R3 R6 R8 copy cycle",
                  {27'd0, tx_sync_out, tx_irq, tx_dma_evt, tx_ready, tx_filled}, 32'h1F);
            collect(nbits(l), w);
            check(w == frame_exp(l, hi, lo), "R4 frame bits", w, frame_exp(l, hi, lo));
            @(negedge clk);
            check(!tx_filled && !tx_dout && !tx_irq, "R8 R11 after frame",
                  {29'd0, tx_filled, tx_dout, tx_irq}, 32'd0);
            repeat (2) @(negedge clk);
        end

        // R5: stale high half with 32-bit frame.
        write_word(2'd2, 1'b0, 16'h0, 16'h2222);
        @(negedge clk);
        collect(32, w);
        check(w == 32'h0001_2222, "R5 stale high half", w, 32'h0001_2222);
        repeat (2) @(negedge clk);

        // R6: sync_in has no effect in per-copy mode.
        pulse_sync();
        w = '0;
        for (int i = 0; i < 4; i++) begin
            w = w | {31'd0, tx_dout};
            @(negedge clk);
        end
        check(w == 0 && !tx_filled, "R6 sync_in ignored", w | {30'd0, tx_filled, 1'b0}, 32'd0);

        // External sync mode.
        sync_sel_int = 1'b0;
        @(negedge clk);
        write_word(2'd0, 1'b0, 16'h0, 16'h005A);
        @(negedge clk);
        check(tx_irq && tx_ready && tx_filled && !tx_sync_out, "R7 staged copy",
              {28'd0, tx_irq, tx_ready, tx_filled, tx_sync_out}, 32'hE);
        w = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            w = w | {31'd0, tx_dout};
        end
        check(w == 0, "R7 R11 waits for sync", w, 32'd0);
        pulse_sync();
        collect(8, w);
        check(w == 32'h5A, "R7 frame on sync", w, 32'h5A);
        @(negedge clk);
        check(!tx_filled, "R8 empty after frame", 32'(tx_filled), 32'd0);

        // R9: underflow resend.
        repeat (2) @(negedge clk);
        pulse_sync();
        check(!tx_filled && !tx_irq, "R9 no fill on resend", {30'd0, tx_filled, tx_irq}, 32'd0);
        collect(8, w);
        check(w == 32'h5A, "R9 resent word", w, 32'h5A);

        // R10: sync during a frame is ignored.
        repeat (2) @(negedge clk);
        write_word(2'd1, 1'b0, 16'h0, 16'h8001);
        @(negedge clk);
        pulse_sync();
        w = '0;
        for (int i = 0; i < 16; i++) begin
            if (i > 0) @(negedge clk);
            w = {w[30:0], tx_dout};
            sync_in = (i == 4);
        end
        sync_in = 1'b0;
        check(w == 32'h8001, "R10 frame intact", w, 32'h8001);
        w = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            w = w | {31'd0, tx_dout};
        end
        check(w == 0, "R10 no extra frame", w, 32'd0);

        // R8: a write during a frame keeps the flag up, then the new word goes out.
        write_word(2'd0, 1'b0, 16'h0, 16'h0011);
        @(negedge clk);
        pulse_sync();
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            wr_lo = (i == 2);
            wr_data = 16'h0022;
        end
        wr_lo = 1'b0;
        @(negedge clk);
        check(tx_filled && !tx_ready, "R8 no underflow after new write",
              {30'd0, tx_filled, tx_ready}, 32'h2);
        @(negedge clk);
        check(tx_irq && tx_ready, "R3 second copy", {30'd0, tx_irq, tx_ready}, 32'h3);
        pulse_sync();
        collect(8, w);
        check(w == 32'h22, "R8 new word sent", w, 32'h22);

        // R7: internal select with free-running generator waits for sync_in.
        repeat (2) @(negedge clk);
        sync_sel_int = 1'b1;
        sync_gen_free = 1'b1;
        write_word(2'd0, 1'b0, 16'h0, 16'h0096);
        @(negedge clk);
        check(!tx_sync_out && !tx_dout, "R7 free-run no pulse", {30'd0, tx_sync_out, tx_dout}, 32'd0);
        repeat (3) @(negedge clk);
        pulse_sync();
        collect(8, w);
        check(w == 32'h96, "R7 free-run frame", w, 32'h96);

        // R1: restart gives zeros on a sync before any write.
        repeat (2) @(negedge clk);
        sync_sel_int = 1'b0;
        sync_gen_free = 1'b0;
        tx_enable = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_ready && !tx_filled && !tx_dout, "R1 disabled state",
              {29'd0, tx_ready, tx_filled, tx_dout}, 32'h4);
        tx_enable = 1'b1;
        repeat (2) @(negedge clk);
        pulse_sync();
        collect(8, w);
        check(w == 0 && !tx_filled, "R1 zeros after restart", w, 32'd0);

        // R12: write before the first sync after restart.
        repeat (2) @(negedge clk);
        tx_enable = 1'b0;
        repeat (2) @(negedge clk);
        tx_enable = 1'b1;
        write_word(2'd0, 1'b0, 16'h0, 16'h00C3);
        @(negedge clk);
        pulse_sync();
        collect(8, w);
        check(w == 32'hC3, "R12 first frame word", w, 32'hC3);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule